// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Burst SRAM

A synchronous static memory with a 36-bit word made of four 9-bit byte lanes. The depth is a parameter and is kept small for simulation. All control, address and write-data inputs are captured on the rising clock edge. The write pipeline has the same depth as the read pipeline, so the shared data timing is the same for both directions. A host can therefore mix reads and writes on every cycle with no idle cycles on the bus.

An operation is started only on a cycle where the load/advance input is low. On that cycle the chip enables and the read/write select are also sampled. Each following cycle with load/advance high continues a four-beat burst, and the block generates the next address itself. The burst runs in linear or interleaved order, chosen by a static order input. An active-low clock enable suspends the whole block. A sleep input makes the block ignore new operations while it keeps the memory contents. An output-enable input qualifies the read-valid flag without a clock.

Top module: `nbt_sram`

## Requirements
- R1: While reset is applied and after it is released, `rvalid` is low until a read has completed.
- R2: A read loaded on an enabled edge updates `rdata` at the second enabled edge after it, with `rvalid` high. Slots holding a write or a deselect leave `rvalid` low.
- R3: Write data is sampled at the second enabled edge after its address. A read issued on the very next cycle after a write to the same address returns the new data, with no idle cycles between them.
- R4: `bw_n[i]` low, sampled with the address, enables lane i (bits 9i+8 to 9i) of a write. Lanes with `bw_n[i]` high keep their contents. A write with all four enables high changes nothing.
- R5: `we_n` is sampled only on load cycles, where 0 means write and 1 means read. On advance cycles its value has no effect.
- R6: `adv_ld` low loads a new operation at `addr` with burst count 0. `adv_ld` high repeats the current operation at the next burst address.
- R7: With `lbo` low, the two low address bits of the burst are the loaded bits plus the count, modulo 4. The upper bits stay fixed.
- R8: With `lbo` high, the two low address bits are the loaded bits XOR the count (0,1,2,3).
- R9: The block is selected only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0 on a load cycle. Otherwise a deselect is loaded, and advances after it stay deselected. A deselect writes nothing and returns no valid data.
- R10: While `cke_n` is high, no input is sampled. The pipeline, the burst count, `rdata` and the registered valid flag all hold.
- R11: While `sleep` is high, loads and advances are ignored and no memory content changes. Operations loaded before sleep still complete.
- R12: `oe_n` high forces `rvalid` low without a clock. When `oe_n` returns low, the pending valid data shows again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cke_n | input | 1 | Active-low clock enable; high suspends the cycle |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| adv_ld | input | 1 | Low loads a new operation, high advances the burst |
| we_n | input | 1 | Operation on load: 0 write, 1 read |
| bw_n | input | 4 | Active-low byte-lane write enables |
| addr | input | AW | Word address |
| lbo | input | 1 | Burst order: 0 linear, 1 interleaved |
| sleep | input | 1 | Power-down request; ignores operations |
| wdata | input | 36 | Write data |
| oe_n | input | 1 | Output enable, active low, applied without a clock |
| rdata | output | 36 | Registered read data |
| rvalid | output | 1 | Read data valid, qualified by `oe_n` |

## Verification
The checker follows each operation through its own two-slot record. This record assumes that `lbo` is held still for the length of a burst. It also assumes that `oe_n` and the other inputs only change away from the rising edge. Its data-hold property is applied only after a read has loaded `rdata`, so unwritten words never reach it. The bench changes every input on the falling edge. It sets `lbo` only between bursts, and it reads back only words it has already written.

// File: rtl/nbt_sram_pkg.sv
package nbt_sram_pkg;
  localparam int BURST_W = 2;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_kind_e;

  // low address bits of one burst beat
  function automatic logic [BURST_W-1:0] burst_low(
    input logic [BURST_W-1:0] base,
    input logic [BURST_W-1:0] cnt,
    input logic               ilv
  );
    return ilv ? (base ^ cnt) : (base + cnt);
  endfunction
endpackage

// File: rtl/nbt_burst_seq.sv
module nbt_burst_seq
  import nbt_sram_pkg::*;
#(
  parameter int AW    = 6,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             sleep,
  input  logic             adv_ld,
  input  logic             we_n,
  input  logic             sel,
  input  logic             ilv,
  input  logic [AW-1:0]    addr,
  input  logic [LANES-1:0] bw_n,
  output op_kind_e         iss_kind,
  output logic [AW-1:0]    iss_addr,
  output logic [LANES-1:0] iss_bw_n
);
  logic [AW-1:0]      base_q, base_d;
  logic [BURST_W-1:0] cnt_q, cnt_d;
  op_kind_e           kind_q, kind_d;

  always_comb begin
    base_d = base_q;
    cnt_d  = cnt_q;
    kind_d = kind_q;
    if (!sleep) begin
      if (!adv_ld) begin
        base_d = addr;
        cnt_d  = '0;
        kind_d = sel ? (we_n ? OP_RD : OP_WR) : OP_NONE;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    iss_kind = sleep ? OP_NONE : kind_d;
    iss_addr = {base_d[AW-1:BURST_W], burst_low(base_d[BURST_W-1:0], cnt_d, ilv)};
    iss_bw_n = bw_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
      kind_q <= OP_NONE;
    end else if (step) begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
      kind_q <= kind_d;
    end
  end
endmodule

// File: rtl/nbt_op_pipe.sv
module nbt_op_pipe
  import nbt_sram_pkg::*;
#(
  parameter int AW     = 6,
  parameter int LANES  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  op_kind_e         in_kind,
  input  logic [AW-1:0]    in_addr,
  input  logic [LANES-1:0] in_bw_n,
  output op_kind_e         out_kind,
  output logic [AW-1:0]    out_addr,
  output logic [LANES-1:0] out_bw_n
);
  op_kind_e         kind_q [STAGES];
  logic [AW-1:0]    addr_q [STAGES];
  logic [LANES-1:0] bw_q   [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) kind_q[i] <= OP_NONE;
    end else if (step) begin
      kind_q[0] <= in_kind;
      for (int i = 1; i < STAGES; i++) kind_q[i] <= kind_q[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (step) begin
      addr_q[0] <= in_addr;
      bw_q[0]   <= in_bw_n;
      for (int i = 1; i < STAGES; i++) begin
        addr_q[i] <= addr_q[i-1];
        bw_q[i]   <= bw_q[i-1];
      end
    end
  end

  assign out_kind = kind_q[STAGES-1];
  assign out_addr = addr_q[STAGES-1];
  assign out_bw_n = bw_q[STAGES-1];
endmodule

// File: rtl/nbt_lane_array.sv
module nbt_lane_array #(
  parameter int AW     = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W,
  localparam int DEPTH = 1 << AW
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    waddr,
  input  logic [DW-1:0]    wdata,
  input  logic [LANES-1:0] wbw_n,
  input  logic [AW-1:0]    raddr,
  output logic [DW-1:0]    rdata
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && !wbw_n[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
  end
endmodule

// File: rtl/nbt_sram.sv
module nbt_sram
  import nbt_sram_pkg::*;
#(
  parameter int AW     = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke_n,
  input  logic             ce1_n,
  input  logic             ce2,
  input  logic             ce3_n,
  input  logic             adv_ld,
  input  logic             we_n,
  input  logic [LANES-1:0] bw_n,
  input  logic [AW-1:0]    addr,
  input  logic             lbo,
  input  logic             sleep,
  input  logic [DW-1:0]    wdata,
  input  logic             oe_n,
  output logic [DW-1:0]    rdata,
  output logic             rvalid
);
  logic rst_meta, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic step, sel;
  assign step = ~cke_n;
  assign sel  = ~ce1_n & ce2 & ~ce3_n;

  op_kind_e         iss_kind, s2_kind;
  logic [AW-1:0]    iss_addr, s2_addr;
  logic [LANES-1:0] iss_bw_n, s2_bw_n;

  nbt_burst_seq #(.AW(AW), .LANES(LANES)) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .step(step), .sleep(sleep),
    .adv_ld(adv_ld), .we_n(we_n), .sel(sel), .ilv(lbo),
    .addr(addr), .bw_n(bw_n),
    .iss_kind(iss_kind), .iss_addr(iss_addr), .iss_bw_n(iss_bw_n)
  );

  nbt_op_pipe #(.AW(AW), .LANES(LANES), .STAGES(2)) u_pipe (
    .clk(clk), .rst_n(rst_sync_n), .step(step),
    .in_kind(iss_kind), .in_addr(iss_addr), .in_bw_n(iss_bw_n),
    .out_kind(s2_kind), .out_addr(s2_addr), .out_bw_n(s2_bw_n)
  );

  logic          arr_we;
  logic [DW-1:0] arr_rdata;
  assign arr_we = step && (s2_kind == OP_WR);

  nbt_lane_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk(clk), .wr_en(arr_we), .waddr(s2_addr), .wdata(wdata),
    .wbw_n(s2_bw_n), .raddr(s2_addr), .rdata(arr_rdata)
  );

  logic [DW-1:0] rd_q;
  logic          rvld_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rvld_q <= 1'b0;
    else if (step)   rvld_q <= (s2_kind == OP_RD);
  end

  always_ff @(posedge clk) begin
    if (step && (s2_kind == OP_RD)) rd_q <= arr_rdata;
  end

  assign rdata  = rd_q;
  assign rvalid = rvld_q & ~oe_n;
endmodule

// File: rtl/nbt_sram_chk.sv
module nbt_sram_chk #(
  parameter int DW = 36
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cke_n,
  input logic          sleep,
  input logic          adv_ld,
  input logic          we_n,
  input logic          ce1_n,
  input logic          ce2,
  input logic          ce3_n,
  input logic          oe_n,
  input logic          rvalid,
  input logic          arr_we,
  input logic [DW-1:0] rdata
);
  // independent slot record: 0 none, 1 read, 2 write
  logic [1:0] trk_q, now_k;
  logic rd1, rd2, rd3, wr1, wr2;

  always_comb begin
    if (sleep)        now_k = 2'd0;
    else if (!adv_ld) now_k = (!ce1_n && ce2 && !ce3_n) ? (we_n ? 2'd1 : 2'd2) : 2'd0;
    else              now_k = trk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trk_q <= 2'd0;
      {rd1, rd2, rd3, wr1, wr2} <= '0;
    end else if (!cke_n) begin
      if (!sleep && !adv_ld) trk_q <= now_k;
      rd1 <= (now_k == 2'd1);
      rd2 <= rd1;
      rd3 <= rd2;
      wr1 <= (now_k == 2'd2);
      wr2 <= wr1;
    end
  end

  assert_valid_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> rd3);
  assert_valid_due_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd3 && !oe_n) |-> rvalid);
  assert_write_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> (wr2 && !cke_n));
  assert_write_due_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr2 && !cke_n) |-> arr_we);
  assert_hold_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cke_n && rd3) |=> $stable(rdata));
  assert_oe_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !rvalid);
endmodule

bind nbt_sram nbt_sram_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .cke_n(cke_n), .sleep(sleep),
  .adv_ld(adv_ld), .we_n(we_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
  .oe_n(oe_n), .rvalid(rvalid), .arr_we(arr_we), .rdata(rdata)
);

// File: tb/nbt_sram_test.sv
`timescale 1ns/1ps
module nbt_sram_test;
  logic        clk = 1'b0;
  logic        rst_n, cke_n, ce1_n, ce2, ce3_n, adv_ld, we_n, lbo, sleep, oe_n;
  logic [3:0]  bw_n;
  logic [5:0]  addr;
  logic [35:0] wdata, rdata;
  logic        rvalid;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  nbt_sram uut (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .ce1_n(ce1_n), .ce2(ce2),
    .ce3_n(ce3_n), .adv_ld(adv_ld), .we_n(we_n), .bw_n(bw_n), .addr(addr),
    .lbo(lbo), .sleep(sleep), .wdata(wdata), .oe_n(oe_n),
    .rdata(rdata), .rvalid(rvalid)
  );

  localparam logic [35:0] BAD = 36'hBADBADBAD;

  task automatic chk(input string rq, input logic [35:0] act, input logic [35:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic chkb(input string rq, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", rq, act, exp);
    end
  endtask

  // one cycle: drive after a falling edge, return at the next falling edge
  task automatic cyc(input int ld, input int wr, input int a,
                     input logic [3:0] bw, input logic [35:0] wd);
    adv_ld = (ld == 0);
    we_n   = (wr == 0);
    addr   = a[5:0];
    bw_n   = bw;
    wdata  = wd;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic nop(input logic [35:0] wd);
    ce1_n = 1'b1;
    cyc(1, 0, 0, 4'hF, wd);
    ce1_n = 1'b0;
  endtask

  task automatic wr1(input int a, input logic [35:0] d);
    cyc(1, 1, a, 4'h0, '0);
    nop('0);
    nop(d);
  endtask

  task automatic rd1(input string rq, input int a, input logic [35:0] exp);
    cyc(1, 0, a, 4'hF, '0);
    nop('0);
    nop('0);
    chk(rq, rdata, exp);
    chkb(rq, rvalid, 1'b1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cke_n = 1'b0; ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
    adv_ld = 1'b1; we_n = 1'b1; lbo = 1'b0; sleep = 1'b0; oe_n = 1'b0;
    bw_n = 4'hF; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    chkb("R1 in reset", rvalid, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chkb("R1 after reset", rvalid, 1'b0);
  endtask

  task automatic t_turnaround();
    cyc(1, 1, 5, 4'h0, '0);
    cyc(1, 0, 5, 4'hF, '0);
    cyc(1, 1, 6, 4'h0, 36'h0A5A5A5A5);
    chkb("R2 write slot no valid", rvalid, 1'b0);
    cyc(1, 0, 6, 4'hF, '0);
    chk("R3 read right after write", rdata, 36'h0A5A5A5A5);
    chkb("R2 read valid", rvalid, 1'b1);
    nop(36'h9C3C3C3C3);
    chkb("R2 write slot no valid", rvalid, 1'b0);
    nop('0);
    chk("R3 second turnaround", rdata, 36'h9C3C3C3C3);
  endtask

  task automatic t_lanes();
    logic [35:0] orig, ones, exp;
    orig = 36'h123456789;
    ones = '1;
    exp  = orig;
    for (int i = 0; i < 4; i++)
      if (i == 0 || i == 2) exp[i*9 +: 9] = ones[i*9 +: 9];
    cyc(1, 1, 10, 4'h0, '0);
    cyc(1, 1, 10, 4'b1010, '0);
    cyc(1, 1, 10, 4'hF, orig);
    cyc(1, 0, 10, 4'hF, ones);
    nop('0);
    nop('0);
    chk("R4 lane mask and no-lane write", rdata, exp);
  endtask

  task automatic t_linear();
    lbo = 1'b0;
    cyc(1, 1, 22, 4'h0, '0);
    cyc(0, 0, 0, 4'h0, '0);
    cyc(0, 0, 0, 4'h0, 36'h100);
    cyc(0, 0, 0, 4'h0, 36'h101);
    cyc(1, 0, 20, 4'hF, 36'h102);
    cyc(1, 0, 21, 4'hF, 36'h103);
    cyc(1, 0, 22, 4'hF, '0);
    chk("R7 linear beat 2 at 20", rdata, 36'h102);
    cyc(1, 0, 23, 4'hF, '0);
    chk("R7 linear beat 3 at 21", rdata, 36'h103);
    nop('0);
    chk("R6 R5 beat 0 at 22", rdata, 36'h100);
    nop('0);
    chk("R6 beat 1 at 23", rdata, 36'h101);
  endtask

  task automatic t_interleave();
    lbo = 1'b1;
    cyc(1, 0, 21, 4'hF, '0);
    cyc(0, 1, 0, 4'h0, '0);
    cyc(0, 1, 0, 4'h0, '0);
    chk("R8 beat 0 addr 21", rdata, 36'h103);
    cyc(0, 1, 0, 4'h0, '0);
    chk("R8 beat 1 addr 20", rdata, 36'h102);
    nop('0);
    chk("R8 beat 2 addr 23", rdata, 36'h101);
    nop('0);
    chk("R8 beat 3 addr 22", rdata, 36'h100);
    lbo = 1'b0;
    rd1("R5 we_n ignored on advance", 22, 36'h100);
    rd1("R5 we_n ignored on advance", 20, 36'h102);
  endtask

  task automatic t_deselect();
    wr1(30, 36'h0DEADBEEF);
    for (int k = 0; k < 3; k++) begin
      if (k == 0) ce1_n = 1'b1;
      if (k == 1) ce2   = 1'b0;
      if (k == 2) ce3_n = 1'b1;
      cyc(1, 1, 30, 4'h0, '0);
      ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
      cyc(0, 1, 0, 4'h0, '0);
      nop(BAD);
      chkb("R9 deselect slot no valid", rvalid, 1'b0);
      nop(BAD);
      chkb("R9 advanced deselect no valid", rvalid, 1'b0);
      rd1("R9 deselect writes nothing", 30, 36'h0DEADBEEF);
    end
  endtask

  task automatic t_suspend();
    wr1(40, 36'h440044004);
    wr1(41, 36'h441144114);
    cyc(1, 0, 40, 4'hF, '0);
    cke_n = 1'b1;
    repeat (3) cyc(1, 1, 41, 4'h0, BAD);
    cke_n = 1'b0;
    nop('0);
    nop('0);
    chk("R10 read after stall", rdata, 36'h440044004);
    cke_n = 1'b1;
    cyc(1, 0, 22, 4'hF, BAD);
    cyc(1, 1, 22, 4'h0, BAD);
    chk("R10 data held", rdata, 36'h440044004);
    chkb("R10 valid held", rvalid, 1'b1);
    cke_n = 1'b0;
    nop('0); nop('0); nop('0);
    rd1("R10 stalled write ignored", 41, 36'h441144114);
    // burst count frozen during suspend
    cyc(1, 0, 20, 4'hF, '0);
    cyc(0, 0, 0, 4'hF, '0);
    cke_n = 1'b1;
    cyc(0, 0, 0, 4'hF, '0);
    cyc(0, 0, 0, 4'hF, '0);
    cke_n = 1'b0;
    cyc(0, 0, 0, 4'hF, '0);
    chk("R10 burst beat 0", rdata, 36'h102);
    nop('0);
    chk("R10 burst beat 1", rdata, 36'h103);
    nop('0);
    chk("R10 burst beat 2 count frozen", rdata, 36'h100);
  endtask

  task automatic t_sleep();
    sleep = 1'b1;
    repeat (3) cyc(1, 1, 40, 4'h0, BAD);
    sleep = 1'b0;
    nop(BAD);
    nop(BAD);
    rd1("R11 memory preserved", 40, 36'h440044004);
    sleep = 1'b1;
    cyc(1, 0, 40, 4'hF, '0);
    sleep = 1'b0;
    nop('0);
    nop('0);
    chkb("R11 read ignored", rvalid, 1'b0);
  endtask

  task automatic t_oe();
    cyc(1, 0, 41, 4'hF, '0);
    nop('0);
    oe_n = 1'b1;
    nop('0);
    chkb("R12 oe_n gates valid", rvalid, 1'b0);
    oe_n = 1'b0;
    #1;
    chkb("R12 valid returns", rvalid, 1'b1);
    chk("R12 data unaffected", rdata, 36'h441144114);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_turnaround();
    t_lanes();
    t_linear();
    t_interleave();
    t_deselect();
    t_suspend();
    t_sleep();
    t_oe();
    finish_run();
  end
endmodule